// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block is a CPU-addressed parallel port peripheral with three 8-bit ports, A, B and C, and one control register. The CPU reaches it through a synchronous register interface. This interface has a chip select, a 2-bit address, and single-cycle read and write strobes. It carries the data on separate input and output buses with an output-enable, so no tri-state bus is needed. Each port pin group comes with an input bus, an output bus and a drive enable, and the pads outside the block use these to build the bidirectional pins.

A mode word written to the control register sets up two groups. Group A is port A plus the upper half of port C. Group B is port B plus the lower half of port C. Each group runs in one of these modes: plain I/O, strobed I/O with a handshake and an interrupt request, or (group A only) a bidirectional handshake. When a group is in a strobed mode, its share of port C stops being general I/O and carries the strobe, acknowledge, buffer-full and interrupt lines. A control write with the top bit clear sets or clears one port C bit. The same single-bit write also turns the interrupt enables on and off.

Top module: `ppi_port_ctrl`

## Requirements
- R1: After reset, the control register reads 0x9B (every port in plain input mode), no port pin is driven (pa_oe=0, pb_oe=0, pc_oe=0x00), and all handshake flags are clear.
- R2: With cs high, address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control register. In plain mode a port written as output drives its latch on the pins and reads back the latch, and a port set as input reads its pins. A direction bit of 1 means input. The mode word fields are: bit 7 = 1, bits 6:5 group A mode (00 plain, 01 strobed, 1x bidirectional), bit 4 port A direction, bit 3 upper C direction, bit 2 group B mode (0 plain, 1 strobed), bit 1 port B direction, bit 0 lower C direction.
- R3: Writing a mode word clears the A, B and C output latches, all buffer-full and interrupt flags, and all interrupt enables.
- R4: A read at address 3 returns the last mode word written, or 0x9B after reset.
- R5: A control write with bit 7 = 0 sets port C bit number din[3:1] to din[0] and leaves the other latch bits unchanged.
- R6: In group A strobed input, a low level on PC4 (strobe, active low) captures pa_in into the port A input latch and sets the input-buffer-full flag, which PC5 drives high. A CPU read of port A returns the captured byte and clears the flag.
- R7: The group A interrupt on PC3 rises when PC4 returns high while the input-buffer-full flag and the input interrupt enable (port C bit 4 written through R5) are both set. It falls on the port A read. With the enable clear it stays low.
- R8: In group A strobed output, a CPU write to port A drives PC7 (output-buffer-full, active low) low. A low on PC6 (acknowledge, active low) releases PC7 high. When PC6 returns high with the output enable set (port C bit 6), PC3 rises. The next port A write drops PC3.
- R9: In group B strobed mode, PC2 is the strobe (input) or acknowledge (output), PC1 is input-buffer-full (active high) or output-buffer-full (active low), PC0 is the group B interrupt, and port C bit 2 is its enable. These follow the same rules as R6 to R8 for port B.
- R10: In group A bidirectional mode, port A drives its pins only while PC6 is low, and a PC4 strobe captures pa_in as in R6. Group B, including PC2..PC0, keeps working independently.
- R11: A port C read returns status in place of pin data at the handshake positions of a strobed group: bit 7 output-buffer-full (active low), bit 6 output enable, bit 5 input-buffer-full, bit 4 input enable, bit 3 group A interrupt, bit 2 group B enable, bit 1 group B buffer flag, bit 0 group B interrupt.
- R12: A handshake works in either order. An acknowledge with no pending write leaves the next write's output-buffer-full flag set. A port read before the strobe returns the previous byte and leaves input-buffer-full clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| addr | input | 2 | Register address |
| rd | input | 1 | Read strobe, one cycle |
| wr | input | 1 | Write strobe, one cycle |
| din | input | 8 | Write data from CPU |
| dout | output | 8 | Read data to CPU |
| doe | output | 1 | Read data valid / bus drive enable |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A pin output |
| pa_oe | output | 1 | Port A drive enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B pin output |
| pb_oe | output | 1 | Port B drive enable |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C pin output |
| pc_oe | output | 8 | Port C per-bit drive enable |

## Verification
A buffer-full or interrupt flag that takes a wrong value appears on its port C handshake pin in the clock edge right after the strobe, acknowledge or CPU access that caused it. The bench samples those pins half a cycle later. A wrong mode decode shows at once on the drive enables and on the port C status read, so one read of port C after each handshake step reveals a stuck flag, a lost enable or a misplaced bit. Ordering faults, such as an acknowledge arriving before the write or a read arriving before the strobe, appear at the latest on the next buffer-full pin sample.

// File: rtl/ppi_port_ctrl.sv
module ppi_port_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic [1:0] addr,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       doe,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic       pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic       pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);

  logic [7:0] ctrl, pa_lat, pb_lat, pc_lat, pa_cap, pb_cap;
  logic ibf_a, obf_a, intr_ai, intr_ao, inte_ai, inte_ao;
  logic ibf_b, obf_b, intr_b, inte_b;
  logic stb_a_q, ack_a_q, hs_b_q;

  wire a_m2 = ctrl[6];
  wire a_m1 = (ctrl[6:5] == 2'b01);
  wire a_in = ctrl[4];
  wire b_m1 = ctrl[2];
  wire b_in = ctrl[1];
  wire a_inmode  = a_m2 | (a_m1 & a_in);
  wire a_outmode = a_m2 | (a_m1 & ~a_in);

  wire wr_a = cs & wr & (addr == 2'd0);
  wire wr_b = cs & wr & (addr == 2'd1);
  wire wr_c = cs & wr & (addr == 2'd2);
  wire wr_k = cs & wr & (addr == 2'd3);
  wire rd_a = cs & rd & (addr == 2'd0);
  wire rd_b = cs & rd & (addr == 2'd1);
  wire mode_wr = wr_k & din[7];
  wire bit_wr  = wr_k & ~din[7];
  wire [2:0] bit_sel = din[3:1];
  wire bit_val = din[0];

  wire stb_a_fall = a_inmode  &  stb_a_q & ~pc_in[4];
  wire stb_a_rise = a_inmode  & ~stb_a_q &  pc_in[4];
  wire ack_a_fall = a_outmode &  ack_a_q & ~pc_in[6];
  wire ack_a_rise = a_outmode & ~ack_a_q &  pc_in[6];
  wire hs_b_fall  = b_m1 &  hs_b_q & ~pc_in[2];
  wire hs_b_rise  = b_m1 & ~hs_b_q &  pc_in[2];

  wire inte_ai_wr = bit_wr & (bit_sel == 3'd4) & a_inmode;
  wire inte_ao_wr = bit_wr & (bit_sel == 3'd6) & a_outmode;
  wire inte_b_wr  = bit_wr & (bit_sel == 3'd2) & b_m1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_a_q <= 1'b1;
      ack_a_q <= 1'b1;
      hs_b_q  <= 1'b1;
    end else begin
      stb_a_q <= pc_in[4];
      ack_a_q <= pc_in[6];
      hs_b_q  <= pc_in[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= 8'h9B;
      pa_lat <= '0;
      pb_lat <= '0;
      pc_lat <= '0;
    end else if (mode_wr) begin
      ctrl   <= din;
      pa_lat <= '0;
      pb_lat <= '0;
      pc_lat <= '0;
    end else begin
      if (wr_a) pa_lat <= din;
      if (wr_b) pb_lat <= din;
      if (wr_c) pc_lat <= din;
      else if (bit_wr) pc_lat[bit_sel] <= bit_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa_cap <= '0;
      pb_cap <= '0;
    end else begin
      if (stb_a_fall) pa_cap <= pa_in;
      if (hs_b_fall && b_in) pb_cap <= pb_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mode_wr) begin
      inte_ai <= 1'b0;
      inte_ao <= 1'b0;
      inte_b  <= 1'b0;
    end else begin
      if (inte_ai_wr) inte_ai <= bit_val;
      if (inte_ao_wr) inte_ao <= bit_val;
      if (inte_b_wr)  inte_b  <= bit_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mode_wr) begin
      ibf_a   <= 1'b0;
      intr_ai <= 1'b0;
    end else begin
      if (stb_a_fall) ibf_a <= 1'b1;
      else if (rd_a && a_inmode) ibf_a <= 1'b0;
      if (inte_ai_wr && !bit_val) intr_ai <= 1'b0;
      else if (stb_a_rise && ibf_a && inte_ai) intr_ai <= 1'b1;
      else if (rd_a && a_inmode) intr_ai <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mode_wr) begin
      obf_a   <= 1'b0;
      intr_ao <= 1'b0;
    end else begin
      if (wr_a && a_outmode) obf_a <= 1'b1;
      else if (ack_a_fall) obf_a <= 1'b0;
      if (inte_ao_wr && !bit_val) intr_ao <= 1'b0;
      else if (wr_a && a_outmode) intr_ao <= 1'b0;
      else if (ack_a_rise && inte_ao && !obf_a) intr_ao <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mode_wr) begin
      ibf_b  <= 1'b0;
      obf_b  <= 1'b0;
      intr_b <= 1'b0;
    end else begin
      if (hs_b_fall && b_in) ibf_b <= 1'b1;
      else if (rd_b && b_m1 && b_in) ibf_b <= 1'b0;
      if (wr_b && b_m1 && !b_in) obf_b <= 1'b1;
      else if (hs_b_fall && !b_in) obf_b <= 1'b0;
      if (inte_b_wr && !bit_val) intr_b <= 1'b0;
      else if (b_m1 && b_in) begin
        if (hs_b_rise && ibf_b && inte_b) intr_b <= 1'b1;
        else if (rd_b) intr_b <= 1'b0;
      end else if (b_m1) begin
        if (wr_b) intr_b <= 1'b0;
        else if (hs_b_rise && inte_b && !obf_b) intr_b <= 1'b1;
      end
    end
  end

  wire [7:0] hs_out   = {a_outmode, 1'b0, a_inmode, 1'b0, a_m1 | a_m2, 1'b0, b_m1, b_m1};
  wire [7:0] hs_in    = {1'b0, a_outmode, 1'b0, a_inmode, 1'b0, b_m1, 2'b00};
  wire [7:0] hs_val   = {~obf_a, 1'b0, ibf_a, 1'b0, intr_ai | intr_ao, 1'b0,
                         b_in ? ibf_b : ~obf_b, intr_b};
  wire [7:0] inte_val = {1'b0, inte_ao, 1'b0, inte_ai, 1'b0, inte_b, 2'b00};
  wire [7:0] gpio_out = {{4{~ctrl[3]}}, {4{~ctrl[0]}}};
  wire [7:0] gpio     = ~(hs_out | hs_in);

  wire [7:0] pc_rd = (hs_out & hs_val) | (hs_in & inte_val) |
                     (gpio & ((gpio_out & pc_lat) | (~gpio_out & pc_in)));
  wire [7:0] pa_rd = a_inmode ? pa_cap : (a_in ? pa_in : pa_lat);
  wire [7:0] pb_rd = (b_m1 && b_in) ? pb_cap : (b_in ? pb_in : pb_lat);

  assign pa_out = pa_lat;
  assign pa_oe  = a_m2 ? ~pc_in[6] : ~a_in;
  assign pb_out = pb_lat;
  assign pb_oe  = ~b_in;
  assign pc_out = (hs_out & hs_val) | (~hs_out & pc_lat);
  assign pc_oe  = hs_out | (gpio & gpio_out);
  assign doe    = cs & rd;

  always_comb begin
    dout = '0;
    if (doe) begin
      case (addr)
        2'd0: dout = pa_rd;
        2'd1: dout = pb_rd;
        2'd2: dout = pc_rd;
        default: dout = ctrl;
      endcase
    end
  end

  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (!ibf_a && !obf_a && !ibf_b && !obf_b && pa_lat == 8'h00 && pb_lat == 8'h00 && pc_lat == 8'h00)); // R3
  AST_IBF_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_inmode && stb_a_q && !pc_in[4] && !mode_wr) |=> ibf_a); // R6
  AST_INTR_NEEDS_INTE: assert property (@(posedge clk) disable iff (!rst_n)
    intr_ai |-> inte_ai); // R7
  AST_OBF_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && a_outmode) |=> (obf_a && !pc_out[7])); // R8
  AST_ACK_CLEARS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
    (a_outmode && ack_a_q && !pc_in[6] && !wr_a) |=> !obf_a); // R8
  AST_BIDIR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_m2 && pa_oe) |-> !pc_in[6]); // R10

endmodule

// File: tb/tb_ppi_port_ctrl.sv
module tb_ppi_port_ctrl;
  logic clk = 0;
  logic rst_n = 0;
  logic cs = 0, rd = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] din = 0;
  logic [7:0] pa_in = 0, pb_in = 0, pc_in = 8'hFF;
  logic [7:0] dout, pa_out, pb_out, pc_out, pc_oe;
  logic doe, pa_oe, pb_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  ppi_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
    .din(din), .dout(dout), .doe(doe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1; wr = 1; addr = a; din = d;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cs = 1; rd = 1; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    cs = 0; rd = 0;
  endtask

  task automatic set_pc(input int b, input logic v);
    @(negedge clk);
    pc_in[b] = v;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    #5;
    if (cs && rd) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard empty actual=%h expected=none", dout);
      end else begin
        chk(dout, exp_q.pop_front(), tag_q.pop_front());
        chk({7'd0, doe}, 8'd1, "R2 doe on read");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({7'd0, pa_oe}, 0, "R1 pa_oe");
    chk({7'd0, pb_oe}, 0, "R1 pb_oe");
    chk(pc_oe, 8'h00, "R1 pc_oe");
    rd_reg(3, 8'h9B, "R1 R4 ctrl reset");

    wr_reg(3, 8'h80);
    rd_reg(3, 8'h80, "R4 ctrl readback");
    wr_reg(0, 8'h5A);
    chk(pa_out, 8'h5A, "R2 pa_out");
    chk({7'd0, pa_oe}, 1, "R2 pa_oe");
    wr_reg(1, 8'hC3);
    chk(pb_out, 8'hC3, "R2 pb_out");
    wr_reg(2, 8'h3C);
    chk(pc_out, 8'h3C, "R2 pc_out");
    chk(pc_oe, 8'hFF, "R2 pc_oe");
    rd_reg(0, 8'h5A, "R2 read output latch");

    wr_reg(3, 8'h0F);
    chk(pc_out, 8'hBC, "R5 set bit7");
    wr_reg(3, 8'h04);
    chk(pc_out, 8'hB8, "R5 clear bit2");

    wr_reg(3, 8'h80);
    chk(pa_out, 8'h00, "R3 pa cleared");
    chk(pb_out, 8'h00, "R3 pb cleared");
    chk(pc_out, 8'h00, "R3 pc cleared");

    wr_reg(3, 8'h9B);
    pa_in = 8'h11; pb_in = 8'h22; pc_in = 8'h33;
    rd_reg(0, 8'h11, "R2 read pa pins");
    rd_reg(1, 8'h22, "R2 read pb pins");
    rd_reg(2, 8'h33, "R2 read pc pins");
    pc_in = 8'hFF;

    wr_reg(3, 8'hB0);
    chk(pc_oe, 8'hEF, "R6 pc_oe strobed input");
    wr_reg(3, 8'h09);
    pa_in = 8'hA7;
    set_pc(4, 0);
    chk({7'd0, pc_out[5]}, 1, "R6 ibf set");
    chk({7'd0, pc_out[3]}, 0, "R7 intr waits for strobe high");
    set_pc(4, 1);
    chk({7'd0, pc_out[3]}, 1, "R7 intr set");
    rd_reg(2, 8'h38, "R11 status ibf inte intr");
    rd_reg(0, 8'hA7, "R6 captured byte");
    chk({7'd0, pc_out[5]}, 0, "R6 ibf cleared by read");
    chk({7'd0, pc_out[3]}, 0, "R7 intr cleared by read");
    rd_reg(2, 8'h10, "R11 status inte only");
    pa_in = 8'h3E;
    rd_reg(0, 8'hA7, "R12 read before strobe old byte");
    chk({7'd0, pc_out[5]}, 0, "R12 ibf stays clear");
    wr_reg(3, 8'h08);
    set_pc(4, 0);
    set_pc(4, 1);
    chk({7'd0, pc_out[5]}, 1, "R6 ibf second strobe");
    chk({7'd0, pc_out[3]}, 0, "R7 intr masked");
    rd_reg(0, 8'h3E, "R12 byte after late strobe");

    wr_reg(3, 8'hA0);
    wr_reg(3, 8'h0D);
    chk({7'd0, pc_out[7]}, 1, "R8 obf idle high");
    wr_reg(0, 8'h96);
    chk(pa_out, 8'h96, "R8 pa_out");
    chk({7'd0, pa_oe}, 1, "R8 pa_oe");
    chk({7'd0, pc_out[7]}, 0, "R8 obf active");
    set_pc(6, 0);
    chk({7'd0, pc_out[7]}, 1, "R8 ack clears obf");
    chk({7'd0, pc_out[3]}, 0, "R8 intr waits for ack high");
    set_pc(6, 1);
    chk({7'd0, pc_out[3]}, 1, "R8 intr after ack");
    wr_reg(0, 8'h97);
    chk({7'd0, pc_out[3]}, 0, "R8 write clears intr");
    rd_reg(2, 8'h40, "R11 status obf inte");
    set_pc(6, 0);
    set_pc(6, 1);
    set_pc(6, 0);
    set_pc(6, 1);
    wr_reg(0, 8'h98);
    @(negedge clk); @(negedge clk);
    chk({7'd0, pc_out[7]}, 0, "R12 obf held after early ack");

    wr_reg(3, 8'h9E);
    wr_reg(3, 8'h05);
    pb_in = 8'h6D;
    set_pc(2, 0);
    chk({7'd0, pc_out[1]}, 1, "R9 ibf_b set");
    set_pc(2, 1);
    chk({7'd0, pc_out[0]}, 1, "R9 intr_b set");
    rd_reg(1, 8'h6D, "R9 captured pb");
    chk({6'd0, pc_out[1:0]}, 0, "R9 ibf_b intr_b cleared");

    wr_reg(3, 8'h84);
    wr_reg(3, 8'h05);
    wr_reg(1, 8'h71);
    chk(pb_out, 8'h71, "R9 pb_out");
    chk({7'd0, pc_out[1]}, 0, "R9 obf_b active");
    set_pc(2, 0);
    chk({7'd0, pc_out[1]}, 1, "R9 ack clears obf_b");
    set_pc(2, 1);
    chk({7'd0, pc_out[0]}, 1, "R9 intr_b after ack");

    wr_reg(3, 8'hC0);
    chk({7'd0, pa_oe}, 0, "R10 no drive without ack");
    wr_reg(0, 8'h4B);
    chk({7'd0, pa_oe}, 0, "R10 no drive after write");
    set_pc(6, 0);
    chk({7'd0, pa_oe}, 1, "R10 drive during ack");
    chk(pa_out, 8'h4B, "R10 pa_out during ack");
    set_pc(6, 1);
    pa_in = 8'hE2;
    set_pc(4, 0);
    set_pc(4, 1);
    chk({7'd0, pc_out[5]}, 1, "R10 ibf in bidir");
    rd_reg(0, 8'hE2, "R10 captured byte");
    wr_reg(1, 8'h19);
    chk(pb_out, 8'h19, "R10 group B plain output");
    chk({7'd0, pb_oe}, 1, "R10 pb_oe");
    wr_reg(3, 8'h03);
    chk({7'd0, pc_out[1]}, 1, "R10 lower C bit set");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule